// File: doc/BRIEF.md
# Double-Buffered Eight-Channel DAC Code Register Bank

This block stores the digital codes of an eight-channel digital-to-analogue converter. Each channel has two 16-bit registers: a staging register that commands write into, and an active register whose value is presented as the channel's conversion code. A serial front end decodes each frame into a command, an address and a data word. It presents them for one cycle on `cmd_valid`. The bank then writes staging registers, copies staging to active registers, or does both.

A load strobe (`ldac_n`, active low) copies every staging register to its active register. Its timing depends on chip select. When the frame is idle, the copy happens right away. When a frame is open, the copy is held until the frame closes, and it then includes any data written by that closing frame. A level-sensitive clear (`clr_n`) forces every register to a preset code. The same preset code is loaded at reset. A strap input, `rst_sel`, chooses zero or mid-scale as the preset. A per-channel pulse tells a power manager which active registers were just loaded, so that it can power those outputs up.

Command codes:
- 0: write staging
- 1: update active
- 2: write staging and update all
- 3: write and update one
- 15: no operation

Address codes:
- 0 to 7: channels 0 to 7
- 15: all channels
- 8 to 14: select nothing

Top module: `dac_reg_bank`

## Requirements
- R1: Command code 0 loads `data` into the staging register of each addressed channel; active codes do not change and `chan_loaded` stays 0.
- R2: Command code 1 copies each addressed channel's staging register into its active register; other channels keep their active code.
- R3: Command code 2 writes `data` into the addressed staging registers and then copies all eight staging registers to the active registers, pulsing all eight `chan_loaded` bits.
- R4: Command code 3 writes `data` into each addressed channel and loads that same value into its active register in the same cycle.
- R5: Address codes 0 to 7 select channel 0 to 7, code 15 selects all channels, and codes 8 to 14 select no channel.
- R6: Commands other than 0 to 3 change no register and ignore `data`; code 15 is the no-operation command.
- R7: A falling edge of `ldac_n` sampled while `cs_n` is high copies every staging register to its active register, visible after the next clock edge.
- R8: A falling edge of `ldac_n` sampled while `cs_n` is low changes nothing until the first cycle in which `cs_n` is high. That cycle then copies all staging registers after applying any command presented in it.
- R9: While `clr_n` is low, all staging and active registers take 0x0000 if `rst_sel` is 0 or 0x8000 if `rst_sel` is 1. This overrides every command and load in the same cycle, and it discards a deferred load.
- R10: Reset (`rst_n` low) loads the same preset as R9 into every register.
- R11: `chan_loaded[i]` is a one-cycle pulse, aligned with the new code, for each active register loaded by a command or by `ldac_n`. It is never set by clear or reset, and an active code never changes without it except through clear or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rst_sel | input | 1 | Preset select: 0 zero-scale, 1 mid-scale |
| clr_n | input | 1 | Synchronous level clear, active low |
| cs_n | input | 1 | Frame chip select, low while a frame is shifting |
| ldac_n | input | 1 | Load strobe, active on its falling edge, synchronous to clk |
| cmd_valid | input | 1 | One-cycle strobe of a decoded frame |
| cmd | input | 4 | Command code |
| addr | input | 4 | Channel address |
| data | input | 16 | Data word |
| dac_code | output | 128 | Active codes, channel i in bits 16*i+15 down to 16*i |
| chan_loaded | output | 8 | Per-channel pulse: active register just loaded |

## Verification
The assertions rely on three assumptions about the inputs. `cmd_valid` is raised only in cycles where `cs_n` is high, since a frame executes when it closes. `ldac_n` is already synchronised to `clk` upstream. All inputs change away from the rising edge. The random stimulus derives `cmd_valid` from the drawn chip-select level, and it drives every input at the falling clock edge. Clear is drawn rarely so that deferred loads, broadcast addresses and reserved codes have time to interact between clears.

// File: rtl/dac_reg_bank.sv
module dac_reg_bank #(
  parameter int NCH = 8,
  parameter int W   = 16,
  parameter int CW  = 4,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rst_sel,
  input  logic           clr_n,
  input  logic           cs_n,
  input  logic           ldac_n,
  input  logic           cmd_valid,
  input  logic [CW-1:0]  cmd,
  input  logic [AW-1:0]  addr,
  input  logic [W-1:0]   data,
  output logic [NCH*W-1:0] dac_code,
  output logic [NCH-1:0] chan_loaded
);
  localparam logic [CW-1:0] OP_WR      = CW'(0);
  localparam logic [CW-1:0] OP_UPD     = CW'(1);
  localparam logic [CW-1:0] OP_WR_ALL  = CW'(2);
  localparam logic [CW-1:0] OP_WR_UPD  = CW'(3);
  localparam logic [AW-1:0] ADDR_ALL   = '1;
  localparam logic [W-1:0]  MID_CODE   = {1'b1, {(W-1){1'b0}}};

  logic ldac_q, pend;

  wire [W-1:0] preset   = rst_sel ? MID_CODE : '0;
  wire ld_fall          = ldac_q & ~ldac_n;
  wire load_all         = cs_n & (ld_fall | pend);
  wire do_wr            = cmd_valid & (cmd == OP_WR || cmd == OP_WR_ALL || cmd == OP_WR_UPD);
  wire upd_every        = cmd_valid & (cmd == OP_WR_ALL);
  wire upd_addressed    = cmd_valid & (cmd == OP_UPD || cmd == OP_WR_UPD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldac_q <= 1'b1;
      pend   <= 1'b0;
    end else begin
      ldac_q <= ldac_n;
      if (!clr_n || load_all) pend <= 1'b0;
      else if (ld_fall)       pend <= 1'b1;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [W-1:0] stage_r, act_r;
    logic         loaded_r;

    wire          hit      = (addr == AW'(g)) || (addr == ADDR_ALL);
    wire [W-1:0]  stage_nx = (do_wr && hit) ? data : stage_r;
    wire          upd      = load_all | upd_every | (upd_addressed & hit);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_r  <= preset;
        act_r    <= preset;
        loaded_r <= 1'b0;
      end else if (!clr_n) begin
        stage_r  <= preset;
        act_r    <= preset;
        loaded_r <= 1'b0;
      end else begin
        stage_r  <= stage_nx;
        if (upd) act_r <= stage_nx;
        loaded_r <= upd;
      end
    end

    assign dac_code[g*W +: W] = act_r;
    assign chan_loaded[g]     = loaded_r;
  end
endmodule

// File: rtl/dac_reg_bank_chk.sv
module dac_reg_bank_chk #(
  parameter int NCH = 8,
  parameter int W   = 16,
  parameter int CW  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sel,
  input logic             clr_n,
  input logic             cs_n,
  input logic             cmd_valid,
  input logic [CW-1:0]    cmd,
  input logic [NCH*W-1:0] dac_code,
  input logic [NCH-1:0]   chan_loaded
);
  localparam logic [W-1:0] MID_CODE = {1'b1, {(W-1){1'b0}}};

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (dac_code == {NCH{($past(rst_sel) ? MID_CODE : {W{1'b0}})}}) && (chan_loaded == '0));

  assert_defer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !cmd_valid) |=> (chan_loaded == '0));

  assert_upd_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == CW'(2) && clr_n) |=> (&chan_loaded));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_loaded == '0 && $past(clr_n)) |-> $stable(dac_code));
endmodule

bind dac_reg_bank dac_reg_bank_chk #(.NCH(NCH), .W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_sel(rst_sel), .clr_n(clr_n), .cs_n(cs_n),
  .cmd_valid(cmd_valid), .cmd(cmd), .dac_code(dac_code), .chan_loaded(chan_loaded)
);

// File: tb/test_dac_reg_bank.sv
module test_dac_reg_bank;
  localparam int NCH = 8;
  localparam int W   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0, rst_sel = 1'b1, clr_n = 1'b1, cs_n = 1'b1, ldac_n = 1'b1, cmd_valid = 1'b0;
  logic [3:0] cmd = 4'hF, addr = 4'h0;
  logic [W-1:0] data = '0;
  logic [NCH*W-1:0] dac_code;
  logic [NCH-1:0] chan_loaded;

  int checks = 0, errors = 0;
  logic [W-1:0] m_in [NCH];
  logic [W-1:0] m_dac [NCH];
  logic m_pend, m_ldq;
  logic [NCH-1:0] m_loaded;

  always #2.5 clk = ~clk;

  dac_reg_bank i_dac_reg_bank (
    .clk(clk), .rst_n(rst_n), .rst_sel(rst_sel), .clr_n(clr_n), .cs_n(cs_n),
    .ldac_n(ldac_n), .cmd_valid(cmd_valid), .cmd(cmd), .addr(addr), .data(data),
    .dac_code(dac_code), .chan_loaded(chan_loaded)
  );

  function automatic bit hits(input logic [3:0] a, input int ch);
    return (a == 4'hF) || (a == 4'(ch));
  endfunction

  function automatic logic [W-1:0] preset_of(input logic sel);
    return sel ? 16'h8000 : 16'h0000;
  endfunction

  function automatic logic [NCH*W-1:0] packed_exp();
    logic [NCH*W-1:0] v;
    for (int i = 0; i < NCH; i++) v[i*W +: W] = m_dac[i];
    return v;
  endfunction

  task automatic model_preset();
    for (int i = 0; i < NCH; i++) begin m_in[i] = preset_of(rst_sel); m_dac[i] = preset_of(rst_sel); end
    m_pend = 1'b0; m_loaded = '0;
  endtask

  task automatic model_edge();
    logic fall, ld_all, wr;
    logic [W-1:0] nx;
    fall = m_ldq && !ldac_n;
    ld_all = cs_n && (fall || m_pend);
    m_ldq = ldac_n;
    if (!clr_n) begin
      model_preset();
      return;
    end
    wr = cmd_valid && (cmd == 4'd0 || cmd == 4'd2 || cmd == 4'd3);
    for (int i = 0; i < NCH; i++) begin
      nx = (wr && hits(addr, i)) ? data : m_in[i];
      m_in[i] = nx;
      m_loaded[i] = ld_all || (cmd_valid && cmd == 4'd2) ||
                    (cmd_valid && (cmd == 4'd1 || cmd == 4'd3) && hits(addr, i));
      if (m_loaded[i]) m_dac[i] = nx;
    end
    if (ld_all) m_pend = 1'b0;
    else if (fall) m_pend = 1'b1;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (dac_code !== packed_exp() || chan_loaded !== m_loaded) begin
      errors++;
      $display("FAIL %s: dac_code=%h loaded=%b expected dac_code=%h loaded=%b",
               tag, dac_code, chan_loaded, packed_exp(), m_loaded);
    end
  endtask

  task automatic step(input string tag, input logic c_clr, input logic c_cs, input logic c_ld,
                      input logic c_v, input logic [3:0] c_cmd, input logic [3:0] c_a,
                      input logic [W-1:0] c_d);
    clr_n = c_clr; cs_n = c_cs; ldac_n = c_ld; cmd_valid = c_v; cmd = c_cmd; addr = c_a; data = c_d;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    m_ldq = 1'b1;
    model_preset();
    repeat (3) @(negedge clk);
    compare("R10 reset to mid-scale");
    rst_n = 1'b1;

    step("R1 write ch2 only staging",  1, 1, 1, 1, 4'd0, 4'd2, 16'h1234);
    step("R2 update ch2",              1, 1, 1, 1, 4'd1, 4'd2, 16'hDEAD);
    step("R4 write+update ch5",        1, 1, 1, 1, 4'd3, 4'd5, 16'hAAAA);
    step("R5 broadcast write",         1, 1, 1, 1, 4'd0, 4'hF, 16'h5555);
    step("R5 reserved address update", 1, 1, 1, 1, 4'd1, 4'd9, 16'h0000);
    step("R5 broadcast update",        1, 1, 1, 1, 4'd1, 4'hF, 16'h0000);
    step("R6 power-down code ignored", 1, 1, 1, 1, 4'd4, 4'd1, 16'hFFFF);
    step("R6 no-op code",              1, 1, 1, 1, 4'hF, 4'hF, 16'hFFFF);
    step("R6 reserved code",           1, 1, 1, 1, 4'd9, 4'd0, 16'hFFFF);
    step("R1 write ch0",               1, 1, 1, 1, 4'd0, 4'd0, 16'h0101);
    step("R3 write ch1 update all",    1, 1, 1, 1, 4'd2, 4'd1, 16'h0202);
    step("R1 write ch3",               1, 1, 1, 1, 4'd0, 4'd3, 16'h7777);
    step("R7 load while idle",         1, 1, 0, 0, 4'hF, 4'h0, 16'h0000);
    step("R7 strobe release",          1, 1, 1, 0, 4'hF, 4'h0, 16'h0000);
    step("R8 frame open",              1, 0, 1, 0, 4'hF, 4'h0, 16'h0000);
    step("R8 load during frame held",  1, 0, 0, 0, 4'hF, 4'h0, 16'h0000);
    step("R8 still held",              1, 0, 1, 0, 4'hF, 4'h0, 16'h0000);
    step("R8 frame close with write",  1, 1, 1, 1, 4'd0, 4'd6, 16'h6666);
    rst_sel = 1'b0;
    step("R9 clear beats write+update", 0, 1, 0, 1, 4'd3, 4'd4, 16'h4444);
    step("R11 no pulse after clear",   1, 1, 1, 0, 4'hF, 4'h0, 16'h0000);
    step("R8 held load",               1, 0, 0, 0, 4'hF, 4'h0, 16'h0000);
    step("R9 clear drops held load",   0, 0, 1, 0, 4'hF, 4'h0, 16'h0000);
    step("R8 no stale load",           1, 1, 1, 1, 4'd0, 4'd7, 16'h7070);
    rst_sel = 1'b1;
    step("R9 clear to mid-scale",      0, 1, 1, 0, 4'hF, 4'h0, 16'h0000);

    for (int n = 0; n < 600; n++) begin
      logic r_cs, r_clr;
      logic [3:0] r_cmd, r_a;
      if ($urandom % 50 == 0) rst_sel = $urandom % 2;
      r_cs  = ($urandom % 4) != 0;
      r_clr = ($urandom % 25) != 0;
      case ($urandom % 8)
        0: r_cmd = 4'd0; 1: r_cmd = 4'd1; 2: r_cmd = 4'd2; 3: r_cmd = 4'd3;
        4: r_cmd = 4'hF; 5: r_cmd = 4'd5; default: r_cmd = 4'($urandom);
      endcase
      r_a = ($urandom % 5 == 0) ? 4'($urandom) : 4'($urandom % 8);
      step("R11 random mix", r_clr, r_cs, ($urandom % 3) != 0,
           r_cs && ($urandom % 2), r_cmd, r_a, 16'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule